// File: doc/BRIEF.md
# Two-Way Tagged Branch Target Cache

This block gives the fetch stage a next address for every fetched PC. It holds the targets of branches that were seen going taken, organised as a small cache. Each of its sets has two ways, and each way keeps a valid bit, an address tag and a full target address. A lookup that finds a valid way whose tag equals the upper PC bits reports a hit and returns that way's target. On a miss the fetch stage continues with the sequential address, which is the PC plus one instruction.

When the execute stage resolves a branch as taken, it presents the branch PC and the computed target on the update port. If the tag is already present in the set, that way's target is overwritten. Otherwise a free way is filled or, when the set is full, the least recently used way is replaced. Branches that resolve not-taken never enter the table. Unconditional direct jumps, which have a single target, can use the same update path.

Lookups are combinational from stored state. A write takes effect at the clock edge, so a lookup made in the same cycle as a write still sees the contents from before it.

Top module: `brtgt_buf`

## Requirements
- R1: After reset every way is invalid, so every lookup misses until an install takes place.
- R2: On a miss, `lk_hit` is 0 and `lk_next_pc` equals `lk_pc + 4`.
- R3: An update with `up_valid=1` and `up_taken=1` installs the mapping. From the next cycle, a lookup of that PC gives `lk_hit=1` and `lk_next_pc` equal to the target. An installed entry stays valid until it is replaced or reset.
- R4: The set index is PC bits [6:2] and the tag is PC bits [31:7]. A lookup hits only when the tag matches. A PC with the same index but a different tag misses, and at most one way hits.
- R5: An update with `up_taken=0` changes nothing. A new PC stays absent, and an existing entry keeps its old target.
- R6: An update whose tag is already present in the set overwrites that way's target and does not allocate a second way, so the other way's entry survives.
- R7: On an update miss, way 0 is filled if it is invalid, otherwise way 1 if it is invalid. If both ways are valid, the least recently used way is replaced.
- R8: A lookup hit with `lk_valid=1`, or any install or overwrite, marks the way used as most recent in its set. A lookup with `lk_valid=0` leaves the recency unchanged.
- R9: A lookup in the same cycle as a write to the same entry returns the contents from before the write.
- R10: When a lookup hit and an update touch the same set in one cycle, the update decides which way becomes most recent.
- R11: Sets are independent: an install in one index does not disturb entries in any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; a hit then updates the recency |
| lk_pc | input | 32 | PC being fetched |
| lk_hit | output | 1 | A tagged entry matched `lk_pc` |
| lk_next_pc | output | 32 | Stored target on a hit, `lk_pc + 4` otherwise |
| up_valid | input | 1 | A resolved branch is presented |
| up_taken | input | 1 | The resolved branch was taken |
| up_pc | input | 32 | PC of the resolved branch |
| up_tgt | input | 32 | Computed target of the resolved branch |

## Verification
A lookup and an update can occur in the same cycle. When they fall in the same set, they contend for the single recency bit and, for an overwrite, for the entry being read. The bench provokes this by issuing a recency-marking lookup of one way while a miss update replaces the other way. The lookup must still return the old target. A follow-up install then shows whether the update's recency choice won: the entry that was just written must survive, and the way the lookup touched must be the one evicted. A separate cycle overwrites an entry while reading it, and the old target must be seen in that cycle and the new one in the next.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

   // Source of a recency change for one set in a given cycle
   typedef enum logic [1:0] {
      TOUCH_NONE   = 2'd0,
      TOUCH_LOOKUP = 2'd1,
      TOUCH_UPDATE = 2'd2
   } touch_src_e;

endpackage

// File: rtl/brtgt_way.sv
module brtgt_way #(
   parameter int SET_CNT = 32,
   parameter int IDX_W   = 5,
   parameter int TAG_W   = 25,
   parameter int PC_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic [TAG_W-1:0]   rd_tag,
   output logic               rd_hit,
   output logic [PC_W-1:0]    rd_tgt,
   input  logic [IDX_W-1:0]   up_idx,
   input  logic [TAG_W-1:0]   up_tag,
   output logic               up_hit,
   output logic               up_occ,
   input  logic               wr_en,
   input  logic [PC_W-1:0]    wr_tgt,
   output logic [SET_CNT-1:0] vld_vec
);

   logic [SET_CNT-1:0] vld_q;
   logic [TAG_W-1:0]   tag_mem [SET_CNT];
   logic [PC_W-1:0]    tgt_mem [SET_CNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[up_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[up_idx] <= up_tag;
         tgt_mem[up_idx] <= wr_tgt;
      end
   end

   always_comb begin
      rd_hit = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
      rd_tgt = tgt_mem[rd_idx];
      up_occ = vld_q[up_idx];
      up_hit = vld_q[up_idx] && (tag_mem[up_idx] == up_tag);
   end

   assign vld_vec = vld_q;

endmodule

// File: rtl/brtgt_lru.sv
module brtgt_lru
   import brtgt_pkg::*;
#(
   parameter int SET_CNT = 32,
   parameter int IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_touch,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic             lk_way,
   input  logic             up_touch,
   input  logic [IDX_W-1:0] up_idx,
   input  logic             up_way,
   output logic             up_vict
);

   logic [SET_CNT-1:0] old_way;

   for (genvar s = 0; s < SET_CNT; s++) begin : g_set
      touch_src_e src;
      logic       bit_q;

      always_comb begin
         if (up_touch && (up_idx == IDX_W'(s)))
            src = TOUCH_UPDATE;
         else if (lk_touch && (lk_idx == IDX_W'(s)))
            src = TOUCH_LOOKUP;
         else
            src = TOUCH_NONE;
      end

      // bit_q names the way to evict next
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else begin
            case (src)
               TOUCH_UPDATE: bit_q <= ~up_way;
               TOUCH_LOOKUP: bit_q <= ~lk_way;
               default:      bit_q <= bit_q;
            endcase
         end
      end

      assign old_way[s] = bit_q;
   end

   assign up_vict = old_way[up_idx];

endmodule

// File: rtl/brtgt_sel.sv
module brtgt_sel #(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0]  hit_vec,
   input  logic [WAYS-1:0]  occ_vec,
   input  logic [WAY_W-1:0] lru_way,
   output logic             any_hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [WAY_W-1:0] fill_way
);

   logic [WAY_W-1:0] free_way;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!occ_vec[w]) free_way = WAY_W'(w);
      end
      any_hit  = |hit_vec;
      fill_way = any_hit ? hit_way : ((&occ_vec) ? lru_way : free_way);
   end

endmodule

// File: rtl/brtgt_buf.sv
module brtgt_buf #(
   parameter int PC_W       = 32,
   parameter int SET_CNT    = 32,
   parameter int WAYS       = 2,
   parameter int INST_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic [PC_W-1:0] lk_next_pc,
   input  logic            up_valid,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_pc,
   input  logic [PC_W-1:0] up_tgt
);

   localparam int ALIGN_LSB = $clog2(INST_BYTES);
   localparam int IDX_W     = $clog2(SET_CNT);
   localparam int TAG_LSB   = ALIGN_LSB + IDX_W;
   localparam int TAG_W     = PC_W - TAG_LSB;
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;

   if (WAYS != 2) begin : g_bad_ways
      $error("brtgt_buf: single-bit recency supports exactly two ways");
   end
   if ((1 << IDX_W) != SET_CNT) begin : g_bad_sets
      $error("brtgt_buf: SET_CNT must be a power of two");
   end
   if ((1 << ALIGN_LSB) != INST_BYTES) begin : g_bad_inst
      $error("brtgt_buf: INST_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("brtgt_buf: PC_W too small for the index");
   end

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;

   assign lk_idx = lk_pc[ALIGN_LSB +: IDX_W];
   assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
   assign up_idx = up_pc[ALIGN_LSB +: IDX_W];
   assign up_tag = up_pc[PC_W-1 -: TAG_W];

   logic                 up_go;
   logic [WAYS-1:0]      lk_way_hit, up_way_hit, up_way_occ, way_wr;
   logic [PC_W-1:0]      way_tgt [WAYS];
   logic [SET_CNT-1:0]   way_vld [WAYS];
   logic [WAYS*SET_CNT-1:0] vld_flat;
   logic                 up_hit_any;
   logic [WAY_W-1:0]     up_hit_way, up_fill_way, lru_vict;

   assign up_go = up_valid && up_taken;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      brtgt_way #(
         .SET_CNT (SET_CNT),
         .IDX_W   (IDX_W),
         .TAG_W   (TAG_W),
         .PC_W    (PC_W)
      ) u_way (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_idx  (lk_idx),
         .rd_tag  (lk_tag),
         .rd_hit  (lk_way_hit[w]),
         .rd_tgt  (way_tgt[w]),
         .up_idx  (up_idx),
         .up_tag  (up_tag),
         .up_hit  (up_way_hit[w]),
         .up_occ  (up_way_occ[w]),
         .wr_en   (way_wr[w]),
         .wr_tgt  (up_tgt),
         .vld_vec (way_vld[w])
      );
      assign way_wr[w] = up_go && (up_fill_way == WAY_W'(w));
      assign vld_flat[w*SET_CNT +: SET_CNT] = way_vld[w];
   end

   brtgt_sel #(
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_sel (
      .hit_vec  (up_way_hit),
      .occ_vec  (up_way_occ),
      .lru_way  (lru_vict),
      .any_hit  (up_hit_any),
      .hit_way  (up_hit_way),
      .fill_way (up_fill_way)
   );

   logic             lk_any;
   logic [WAY_W-1:0] lk_way;
   logic [PC_W-1:0]  lk_tgt;

   always_comb begin
      lk_any = 1'b0;
      lk_way = '0;
      lk_tgt = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_way_hit[w]) begin
            lk_any = 1'b1;
            lk_way = WAY_W'(w);
            lk_tgt = lk_tgt | way_tgt[w];
         end
      end
   end

   brtgt_lru #(
      .SET_CNT (SET_CNT),
      .IDX_W   (IDX_W)
   ) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_touch (lk_valid && lk_any),
      .lk_idx   (lk_idx),
      .lk_way   (lk_way[0]),
      .up_touch (up_go),
      .up_idx   (up_idx),
      .up_way   (up_fill_way[0]),
      .up_vict  (lru_vict[0])
   );

   assign lk_hit     = lk_any;
   assign lk_next_pc = lk_any ? lk_tgt : (lk_pc + PC_W'(INST_BYTES));

endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk #(
   parameter int PC_W    = 32,
   parameter int SET_CNT = 32,
   parameter int WAYS    = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [PC_W-1:0]         lk_pc,
   input logic                    lk_hit,
   input logic [PC_W-1:0]         lk_next_pc,
   input logic                    up_valid,
   input logic                    up_taken,
   input logic [PC_W-1:0]         up_pc,
   input logic [PC_W-1:0]         up_tgt,
   input logic [WAYS*SET_CNT-1:0] vld_flat,
   input logic                    up_hit_any,
   input logic [WAYS-1:0]         lk_way_hit
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (vld_flat == '0));

   // R3
   install_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken) |=>
         ((lk_pc != $past(up_pc)) || (lk_hit && (lk_next_pc == $past(up_tgt)))));

   // R3
   entry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(vld_flat) >= $countones($past(vld_flat))));

   // R5
   nottaken_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_valid && up_taken) |=> $stable(vld_flat));

   // R6
   overwrite_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && up_hit_any) |=> $stable(vld_flat));

   // R4
   single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_way_hit));

endmodule

bind brtgt_buf brtgt_chk #(
   .PC_W    (PC_W),
   .SET_CNT (SET_CNT),
   .WAYS    (WAYS)
) u_brtgt_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_pc      (lk_pc),
   .lk_hit     (lk_hit),
   .lk_next_pc (lk_next_pc),
   .up_valid   (up_valid),
   .up_taken   (up_taken),
   .up_pc      (up_pc),
   .up_tgt     (up_tgt),
   .vld_flat   (vld_flat),
   .up_hit_any (up_hit_any),
   .lk_way_hit (lk_way_hit)
);

// File: tb/brtgt_buf_bench.sv
module brtgt_buf_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_next_pc;
   logic        up_valid = 1'b0;
   logic        up_taken = 1'b0;
   logic [31:0] up_pc = '0;
   logic [31:0] up_tgt = '0;

   always #4 clk = ~clk;

   brtgt_buf u_brtgt_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_valid   (lk_valid),
      .lk_pc      (lk_pc),
      .lk_hit     (lk_hit),
      .lk_next_pc (lk_next_pc),
      .up_valid   (up_valid),
      .up_taken   (up_taken),
      .up_pc      (up_pc),
      .up_tgt     (up_tgt)
   );

   typedef struct {
      logic        hit;
      logic [31:0] nxt;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   function automatic logic [31:0] mk(input int tag, input int idx);
      return {tag[24:0], idx[4:0], 2'b00};
   endfunction

   // One cycle: drive inputs at the falling edge, queue the expected lookup result
   task automatic cyc(input logic do_chk, input logic lv, input logic [31:0] lpc,
                      input logic ehit, input logic [31:0] etgt,
                      input logic uv, input logic ut, input logic [31:0] upc,
                      input logic [31:0] utgt, input string req);
      exp_t e;
      @(negedge clk);
      lk_valid = lv;  lk_pc = lpc;
      up_valid = uv;  up_taken = ut;  up_pc = upc;  up_tgt = utgt;
      #1;
      if (do_chk) begin
         e.hit = ehit;
         e.nxt = ehit ? etgt : lpc + 32'd4;
         e.req = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic peek(input logic [31:0] pc, input logic h, input logic [31:0] t, input string req);
      cyc(1'b1, 1'b0, pc, h, t, 1'b0, 1'b0, '0, '0, req);
   endtask

   task automatic touch(input logic [31:0] pc, input logic h, input logic [31:0] t, input string req);
      cyc(1'b1, 1'b1, pc, h, t, 1'b0, 1'b0, '0, '0, req);
   endtask

   task automatic put(input logic [31:0] pc, input logic [31:0] t, input logic tk);
      cyc(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, tk, pc, t, "");
   endtask

   // Monitor: compares queued expectations two units after the falling edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (lk_hit !== e.hit || lk_next_pc !== e.nxt) begin
               n_bad++;
               $display("FAIL %s: hit=%0b next=%h expected hit=%0b next=%h",
                        e.req, lk_hit, lk_next_pc, e.hit, e.nxt);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   localparam logic [31:0] TA = 32'h0000_4000, TA2 = 32'h0000_4800, TB = 32'h0000_5000;
   localparam logic [31:0] TC = 32'h0000_6000, TD = 32'h0000_7000, TE = 32'h0000_8000;
   localparam logic [31:0] TF = 32'h0000_9000, TX = 32'h0000_A000;

   initial begin
      logic [31:0] pa, pb, pc, pd, pe, pf;
      pa = mk(1, 3); pb = mk(2, 3); pc = mk(3, 3);
      pd = mk(4, 3); pf = mk(6, 3); pe = mk(5, 9);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R2: empty table, sequential next PC
      peek(pa, 1'b0, '0, "R1");
      peek(pe, 1'b0, '0, "R2");

      // R3: install then hit; R11: other index unaffected; R4: same index other tag
      put(pa, TA, 1'b1);
      peek(pa, 1'b1, TA, "R3");
      peek(mk(1, 4), 1'b0, '0, "R11");
      peek(pb, 1'b0, '0, "R4");

      // R5: not-taken updates change nothing
      put(pb, TB, 1'b0);
      peek(pb, 1'b0, '0, "R5");
      put(pa, TX, 1'b0);
      peek(pa, 1'b1, TA, "R5");

      // R7: second way filled while first is valid
      put(pb, TB, 1'b1);
      peek(pa, 1'b1, TA, "R7");
      peek(pb, 1'b1, TB, "R7");

      // R8: marking lookup of A makes B the victim for C
      touch(pa, 1'b1, TA, "R8");
      put(pc, TC, 1'b1);
      peek(pb, 1'b0, '0, "R8");
      peek(pa, 1'b1, TA, "R8");
      peek(pc, 1'b1, TC, "R7");

      // R9 + R6: overwrite A while reading it
      cyc(1'b1, 1'b0, pa, 1'b1, TA, 1'b1, 1'b1, pa, TA2, "R9");
      peek(pa, 1'b1, TA2, "R6");
      peek(pc, 1'b1, TC, "R6");

      // R10: lookup marks A while update D replaces C in the same set
      cyc(1'b1, 1'b1, pa, 1'b1, TA2, 1'b1, 1'b1, pd, TD, "R9");
      peek(pc, 1'b0, '0, "R10");
      peek(pd, 1'b1, TD, "R10");
      put(pf, TF, 1'b1);
      peek(pa, 1'b0, '0, "R10");
      peek(pd, 1'b1, TD, "R10");
      peek(pf, 1'b1, TF, "R10");

      // R11: another set is independent
      put(pe, TE, 1'b1);
      peek(pe, 1'b1, TE, "R11");
      peek(pd, 1'b1, TD, "R11");

      // R1: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      peek(pd, 1'b0, '0, "R1");
      peek(pe, 1'b0, '0, "R1");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule